// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block is the digital controller that sits in front of a multi-channel sigma-delta converter. Software reaches it over a small byte-wide register bus. Through that bus it picks what starts a conversion sequence: nothing, free running, a timer compare event, or a software go bit. It also programs the last channel of the sequence and the reference and decimation rate to use. The controller walks the sequence one channel at a time. For each step it hands the converter a request that carries channel, reference and rate, and it waits for the converter's done pulse and 12-bit result.

A separate extra-conversion register runs one conversion with its own channel, reference and rate each time it is written. If a sequence is running when that write arrives, the extra conversion waits until the conversion in flight finishes. It then runs, and the sequence resumes where it stopped.

Results are stored left-justified across a high and a low result byte. Bits below the resolution that the decimation rate gives are cleared. A done flag marks fresh data and is cleared by reading the high byte.

Top module: `adcseq_ctrl`

## Requirements
- R1: After synchronous reset every register reads 0x00 (control, sequence config, extra config, result low, result high) and the converter request is low.
- R2: Control register (address 0) layout: bits [1:0] start mode, bit 2 go on write / busy on read, bit 3 done flag (read only). Writing bit 2 = 1 together with start mode 11 starts a sequence only when none is running. Busy reads 1 from the cycle after the start until the last channel of the sequence completes.
- R3: With start mode 01 a new sequence starts on its own as soon as the previous one ends, with no trigger.
- R4: With start mode 10 a one-cycle pulse on `tmr_evt` while idle starts a sequence. With start mode 00 no sequence starts, even if the go bit is written.
- R5: Sequence config (address 1) layout: bits [3:0] end channel, [5:4] rate code, [7:6] reference code. An end channel of 0..7 converts single-ended channel codes 0, 1, … up to the end channel, in increasing order.
- R6: An end channel of 8..11 converts the differential pair codes 8, 9, … up to the end channel, in increasing order.
- R7: An end channel of 12..15 (12 ground, 13 reserved, 14 temperature, 15 supply/3) performs exactly one conversion, on that code.
- R8: Reading address 1 returns the reference and rate fields in bits [7:4] and, in bits [3:0], the channel code of the conversion in progress (the last one converted when idle).
- R9: Each converter request carries the channel, reference code and rate code in effect, and holds `cv_req` and all its fields steady until `cv_done` is seen.
- R10: Writing the extra config register (address 2, same field layout as address 1) requests one conversion using its own fields. During a sequence it runs right after the conversion in flight, and the remaining channels follow.
- R11: The done flag sets when any conversion completes, stays set while later conversions complete, and clears when address 4 (result high) is read.
- R12: Rate codes 00/01/10/11 mean decimation 64/128/256/512 and keep 7/9/10/12 result bits. The 12-bit result is placed in bits [15:4] of a 16-bit word with the bits below the kept width zeroed. Address 4 returns word bits [15:8]. Address 3 returns word bits [7:2] in its bits [7:2], and its bits [1:0] are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_rd` |
| tmr_evt | input | 1 | Timer compare event pulse |
| cv_req | output | 1 | Conversion request to the converter |
| cv_chan | output | 4 | Channel code of the request |
| cv_ref | output | 2 | Reference code of the request |
| cv_rate | output | 2 | Decimation rate code of the request |
| cv_done | input | 1 | Converter done pulse |
| cv_result | input | 12 | Converter result, valid with `cv_done` |

## Verification
The bench goes after the start-condition corners. A go bit written under start mode 00 must start nothing, and a second go while busy must not add a sequence. A design that got either wrong would issue extra requests, which the scoreboard reports as unexpected. The bench also checks the three ranges of the end-channel code, where a controller that treated 8..11 as single-ended or converted more than once for 12..15 would send the wrong channel order. An extra conversion is injected mid-sequence, so a design that dropped it, ran it late or restarted the sequence after it shows a mismatch in request order. Result masking is checked at every rate, and the flag is checked for staying set over several conversions and clearing only on the high-byte read.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  localparam int CH_W   = 4;
  localparam int FULL_W = 16;

  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_SEQ  = 3'd1;
  localparam logic [2:0] ADR_XTRA = 3'd2;
  localparam logic [2:0] ADR_RLO  = 3'd3;
  localparam logic [2:0] ADR_RHI  = 3'd4;

  typedef enum logic [1:0] {
    START_NONE  = 2'b00,
    START_FREE  = 2'b01,
    START_TIMER = 2'b10,
    START_SOFT  = 2'b11
  } start_mode_e;

  // kept result width for a decimation code
  function automatic int unsigned eff_bits(input logic [1:0] rate);
    case (rate)
      2'b00:   return 7;
      2'b01:   return 9;
      2'b10:   return 10;
      default: return 12;
    endcase
  endfunction

  // first channel code of a sequence ending at end_code
  function automatic logic [CH_W-1:0] first_ch(input logic [CH_W-1:0] end_code);
    if (end_code <= 4'd7)       return '0;
    else if (end_code <= 4'd11) return 4'd8;
    else                        return end_code;
  endfunction

endpackage

// File: rtl/adcseq_regs.sv
module adcseq_regs
  import adcseq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              flag,
  input  logic [CH_W-1:0]   cur_ch,
  input  logic [DATA_W-1:0] res_hi,
  input  logic [DATA_W-1:0] res_lo,
  output start_mode_e       mode,
  output logic [CH_W-1:0]   seq_end,
  output logic [1:0]        seq_rate,
  output logic [1:0]        seq_ref,
  output logic [CH_W-1:0]   x_ch,
  output logic [1:0]        x_rate,
  output logic [1:0]        x_ref,
  output logic              go_req,
  output logic              x_trig,
  output logic              hi_read
);

  logic [DATA_W-1:0] seq_cfg_q, x_cfg_q;
  logic [DATA_W-1:0] rd_mux;
  logic              at_ctrl, at_seq, at_xtra;

  assign at_ctrl = (bus_addr == ADDR_W'(ADR_CTRL));
  assign at_seq  = (bus_addr == ADDR_W'(ADR_SEQ));
  assign at_xtra = (bus_addr == ADDR_W'(ADR_XTRA));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= START_NONE;
      seq_cfg_q <= '0;
      x_cfg_q   <= '0;
    end else if (bus_wr) begin
      if (at_ctrl) mode      <= start_mode_e'(bus_wdata[1:0]);
      if (at_seq)  seq_cfg_q <= bus_wdata;
      if (at_xtra) x_cfg_q   <= bus_wdata;
    end
  end

  assign seq_end  = seq_cfg_q[3:0];
  assign seq_rate = seq_cfg_q[5:4];
  assign seq_ref  = seq_cfg_q[7:6];
  assign x_ch     = x_cfg_q[3:0];
  assign x_rate   = x_cfg_q[5:4];
  assign x_ref    = x_cfg_q[7:6];

  assign go_req  = bus_wr && at_ctrl && bus_wdata[2] &&
                   (bus_wdata[1:0] == START_SOFT);
  assign x_trig  = bus_wr && at_xtra;
  assign hi_read = bus_rd && (bus_addr == ADDR_W'(ADR_RHI));

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(ADR_CTRL): rd_mux = {4'b0000, flag, busy, mode};
      ADDR_W'(ADR_SEQ):  rd_mux = {seq_cfg_q[7:4], cur_ch};
      ADDR_W'(ADR_XTRA): rd_mux = x_cfg_q;
      ADDR_W'(ADR_RLO):  rd_mux = res_lo;
      ADDR_W'(ADR_RHI):  rd_mux = res_hi;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R12
  lo_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(ADR_RLO)) |=> (bus_rdata[1:0] == 2'b00));

endmodule

// File: rtl/adcseq_sched.sv
module adcseq_sched
  import adcseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  start_mode_e     mode,
  input  logic [CH_W-1:0] seq_end,
  input  logic [1:0]      seq_rate,
  input  logic [1:0]      seq_ref,
  input  logic [CH_W-1:0] x_ch,
  input  logic [1:0]      x_rate,
  input  logic [1:0]      x_ref,
  input  logic            go_req,
  input  logic            x_trig,
  input  logic            tmr_evt,
  input  logic            cv_done,
  output logic            busy,
  output logic [CH_W-1:0] cur_ch,
  output logic            cap_en,
  output logic            cv_req,
  output logic [CH_W-1:0] cv_chan,
  output logic [1:0]      cv_ref,
  output logic [1:0]      cv_rate
);

  logic            seq_act, inflight, infl_x, x_pend, start;
  logic [CH_W-1:0] seq_last;

  always_comb begin
    start = 1'b0;
    if (!seq_act) begin
      case (mode)
        START_FREE:  start = 1'b1;
        START_TIMER: start = tmr_evt;
        default:     start = 1'b0;
      endcase
      if (go_req) start = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_act  <= 1'b0;
      inflight <= 1'b0;
      infl_x   <= 1'b0;
      x_pend   <= 1'b0;
      cur_ch   <= '0;
      seq_last <= '0;
      cv_req   <= 1'b0;
      cv_chan  <= '0;
      cv_ref   <= '0;
      cv_rate  <= '0;
    end else begin
      if (start) begin
        seq_act  <= 1'b1;
        seq_last <= seq_end;
        cur_ch   <= first_ch(seq_end);
      end
      if (!inflight) begin
        if (x_pend) begin
          inflight <= 1'b1;
          infl_x   <= 1'b1;
          x_pend   <= 1'b0;
          cv_req   <= 1'b1;
          cv_chan  <= x_ch;
          cv_rate  <= x_rate;
          cv_ref   <= x_ref;
        end else if (seq_act) begin
          inflight <= 1'b1;
          infl_x   <= 1'b0;
          cv_req   <= 1'b1;
          cv_chan  <= cur_ch;
          cv_rate  <= seq_rate;
          cv_ref   <= seq_ref;
        end
      end else if (cv_done) begin
        inflight <= 1'b0;
        cv_req   <= 1'b0;
        if (!infl_x) begin
          if (cur_ch == seq_last) seq_act <= 1'b0;
          else                    cur_ch  <= cur_ch + 1'b1;
        end
      end
      if (x_trig) x_pend <= 1'b1;
    end
  end

  assign busy   = seq_act;
  assign cap_en = inflight && cv_done;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cv_req && !cv_done) |=> (cv_req && $stable(cv_chan) &&
                              $stable(cv_rate) && $stable(cv_ref)));

  // R4
  no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!seq_act && mode == START_NONE && !go_req) |=> !seq_act);

  // R5
  chan_range_chk: assert property (@(posedge clk) disable iff (rst)
    seq_act |-> (cur_ch <= seq_last));

endmodule

// File: rtl/adcseq_result.sv
module adcseq_result
  import adcseq_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [RES_W-1:0]  cv_result,
  input  logic [1:0]        rate,
  input  logic              hi_read,
  output logic [DATA_W-1:0] res_hi,
  output logic [DATA_W-1:0] res_lo,
  output logic              flag
);

  localparam int PAD_W = FULL_W - RES_W;

  logic [FULL_W-1:0] lj, keep, word;

  assign lj   = {cv_result, {PAD_W{1'b0}}};
  assign keep = ~({FULL_W{1'b1}} >> eff_bits(rate));
  assign word = lj & keep;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_hi <= '0;
      res_lo <= '0;
      flag   <= 1'b0;
    end else begin
      if (cap_en) begin
        res_hi <= word[FULL_W-1 -: DATA_W];
        res_lo <= {word[DATA_W-1:2], 2'b00};
      end
      if (cap_en)       flag <= 1'b1;
      else if (hi_read) flag <= 1'b0;
    end
  end

  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> flag);

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tmr_evt,
  output logic              cv_req,
  output logic [CH_W-1:0]   cv_chan,
  output logic [1:0]        cv_ref,
  output logic [1:0]        cv_rate,
  input  logic              cv_done,
  input  logic [RES_W-1:0]  cv_result
);

  start_mode_e       mode;
  logic [CH_W-1:0]   seq_end, x_ch, cur_ch;
  logic [1:0]        seq_rate, seq_ref, x_rate, x_ref;
  logic              go_req, x_trig, hi_read, busy, flag, cap_en;
  logic [DATA_W-1:0] res_hi, res_lo;

  adcseq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .busy(busy), .flag(flag), .cur_ch(cur_ch),
    .res_hi(res_hi), .res_lo(res_lo),
    .mode(mode), .seq_end(seq_end), .seq_rate(seq_rate), .seq_ref(seq_ref),
    .x_ch(x_ch), .x_rate(x_rate), .x_ref(x_ref),
    .go_req(go_req), .x_trig(x_trig), .hi_read(hi_read)
  );

  adcseq_sched u_sched (
    .clk(clk), .rst(rst), .mode(mode),
    .seq_end(seq_end), .seq_rate(seq_rate), .seq_ref(seq_ref),
    .x_ch(x_ch), .x_rate(x_rate), .x_ref(x_ref),
    .go_req(go_req), .x_trig(x_trig), .tmr_evt(tmr_evt), .cv_done(cv_done),
    .busy(busy), .cur_ch(cur_ch), .cap_en(cap_en),
    .cv_req(cv_req), .cv_chan(cv_chan), .cv_ref(cv_ref), .cv_rate(cv_rate)
  );

  adcseq_result #(.RES_W(RES_W), .DATA_W(DATA_W)) u_result (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cv_result(cv_result),
    .rate(cv_rate), .hi_read(hi_read),
    .res_hi(res_hi), .res_lo(res_lo), .flag(flag)
  );

endmodule

// File: tb/adcseq_ctrl_bench.sv
module adcseq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, tmr_evt = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        cv_req, cv_done;
  logic [3:0]  cv_chan;
  logic [1:0]  cv_ref, cv_rate;
  logic [11:0] cv_result;

  int checks = 0, fails = 0, req_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcseq_ctrl u_adcseq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tmr_evt(tmr_evt), .cv_req(cv_req), .cv_chan(cv_chan), .cv_ref(cv_ref),
    .cv_rate(cv_rate), .cv_done(cv_done), .cv_result(cv_result)
  );

  function automatic logic [11:0] stub_val(input logic [3:0] ch);
    return 12'hA5C ^ {ch, ch, ch};
  endfunction

  // expected {high byte, low byte} for a channel and rate code (R12)
  function automatic logic [15:0] exp_bytes(input logic [3:0] ch, input logic [1:0] rate);
    logic [15:0] w;
    int unsigned n;
    n = (rate == 2'd0) ? 7 : (rate == 2'd1) ? 9 : (rate == 2'd2) ? 10 : 12;
    w = {stub_val(ch), 4'h0} & ~(16'hFFFF >> n);
    return {w[15:8], w[7:2], 2'b00};
  endfunction

  // converter stand-in: latency grows with rate
  int  stub_cnt = 0;
  logic stub_busy = 1'b0;
  always @(posedge clk) begin
    if (rst) begin
      stub_busy <= 1'b0; cv_done <= 1'b0; cv_result <= '0; stub_cnt <= 0;
    end else if (cv_done) begin
      cv_done <= 1'b0;
    end else if (!stub_busy && cv_req) begin
      stub_busy <= 1'b1;
      stub_cnt  <= (4 << cv_rate) - 1;
    end else if (stub_busy) begin
      if (stub_cnt == 0) begin
        cv_done   <= 1'b1;
        cv_result <= stub_val(cv_chan);
        stub_busy <= 1'b0;
      end else stub_cnt <= stub_cnt - 1;
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // scoreboard of expected converter requests
  typedef struct packed { logic [3:0] ch; logic [1:0] rate; logic [1:0] rf; } exp_t;
  exp_t exp_q[$];

  task automatic push(input logic [3:0] ch, input logic [1:0] rate, input logic [1:0] rf);
    exp_q.push_back({ch, rate, rf});
  endtask

  logic req_seen = 1'b0;
  always @(negedge clk) begin
    if (!rst && cv_req && !req_seen) begin
      req_seen = 1'b1;
      req_count++;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2/R4: unexpected request ch %h, expected none", cv_chan);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R5/R6/R7/R10 channel order", {12'h0, cv_chan}, {12'h0, e.ch});
        chk("R9 rate and reference", {12'h0, cv_rate, cv_ref}, {12'h0, e.rate, e.rf});
      end
    end
    if (!cv_req) req_seen = 1'b0;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || cv_req) && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_req_ch(input logic [3:0] ch);
    int n = 0;
    while (!(cv_req && cv_chan == ch) && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic check_result(input string tag, input logic [3:0] ch, input logic [1:0] rate);
    logic [7:0] hi, lo;
    rd(3'd4, hi);
    rd(3'd3, lo);
    chk(tag, {hi, lo}, exp_bytes(ch, rate));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", {8'h0, d}, 16'h0);
    end
    chk("R1 request low", {15'h0, cv_req}, 16'h0);

    // R5 single-ended scan 0..3, rate 01, ref 10, software go
    wr(3'd1, 8'h93);
    for (int c = 0; c < 4; c++) push(4'(c), 2'd1, 2'd2);
    wr(3'd0, 8'h07);
    rd(3'd0, d);
    chk("R2 busy after go", {8'h0, d}, 16'h0007);
    wait_req_ch(4'd2);
    rd(3'd1, d);
    chk("R8 current channel readback", {8'h0, d}, 16'h0092);
    drain();
    rd(3'd0, d);
    chk("R11 flag held over several conversions, R2 busy clear", {8'h0, d}, 16'h000B);
    check_result("R12 result rate 9 bits", 4'd3, 2'd1);
    rd(3'd0, d);
    chk("R11 flag cleared by high read", {8'h0, d}, 16'h0003);

    // R4 go under mode 00 does nothing
    base = req_count;
    wr(3'd0, 8'h04);
    repeat (30) @(negedge clk);
    chk("R4 no start in mode 00", 16'(req_count - base), 16'h0);
    rd(3'd0, d);
    chk("R2 idle under mode 00", {8'h0, d}, 16'h0000);

    // R6 differential pairs 8..10, rate 11
    wr(3'd1, 8'h3A);
    for (int c = 8; c < 11; c++) push(4'(c), 2'd3, 2'd0);
    wr(3'd0, 8'h07);
    drain();
    check_result("R6 R12 result rate 12 bits", 4'd10, 2'd3);

    // R7 single conversion on code 14, second go while busy ignored
    base = req_count;
    wr(3'd1, 8'h0E);
    push(4'd14, 2'd0, 2'd0);
    wr(3'd0, 8'h07);
    wr(3'd0, 8'h07);
    drain();
    chk("R7 R2 exactly one conversion", 16'(req_count - base), 16'd1);
    check_result("R7 R12 result rate 7 bits", 4'd14, 2'd0);

    // R4 timer start
    base = req_count;
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h41);
    push(4'd0, 2'd0, 2'd1);
    push(4'd1, 2'd0, 2'd1);
    @(negedge clk); tmr_evt = 1'b1;
    @(negedge clk); tmr_evt = 1'b0;
    drain();
    chk("R4 timer sequence length", 16'(req_count - base), 16'd2);
    wr(3'd0, 8'h00);

    // R10 extra conversion while idle
    wr(3'd2, 8'hCF);
    push(4'd15, 2'd0, 2'd3);
    drain();
    check_result("R10 R12 extra result", 4'd15, 2'd0);

    // R10 extra conversion queued inside a sequence
    wr(3'd1, 8'h02);
    push(4'd0, 2'd0, 2'd0);
    push(4'd12, 2'd2, 2'd1);
    push(4'd1, 2'd0, 2'd0);
    push(4'd2, 2'd0, 2'd0);
    wr(3'd0, 8'h07);
    wait_req_ch(4'd0);
    wr(3'd2, 8'h6C);
    drain();
    chk("R10 queue drained in order", 16'(exp_q.size()), 16'h0);
    check_result("R10 R12 sequence resumed result", 4'd2, 2'd0);

    // R3 free running, three back-to-back sequences
    base = req_count;
    wr(3'd1, 8'h20);
    for (int k = 0; k < 3; k++) push(4'd0, 2'd2, 2'd0);
    wr(3'd0, 8'h01);
    begin
      int n = 0;
      while (exp_q.size() != 0 && n < 5000) begin @(negedge clk); n++; end
    end
    wr(3'd0, 8'h00);
    drain();
    chk("R3 back-to-back sequences", 16'(req_count - base), 16'd3);
    rd(3'd0, d);
    chk("R3 stopped after mode cleared", {8'h0, d[2], 7'h0}, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule